// File: doc/BRIEF.md
# Serial Port Modem Handshake Controller

This block carries the modem handshake slice of a 16550-style serial port. Software writes a modem control byte over a small CPU register bus. That byte drives two active-low handshake outputs: request-to-send and data-terminal-ready. A loopback bit in the same byte forces both outputs to their inactive level. The clear-to-send input passes through a synchronizer. Its current level and a sticky change flag are reported in a modem status byte, and the flag raises a modem-status interrupt when software has enabled it.

The request-to-send pin is shared with a strap function. At the first clock edge after hardware reset is released, the pin level seen on the strap input picks the configuration index base address, either 3F0 hex or 370 hex. That choice holds until the next reset. The CPU bus is plain: a read or write strobe, an address and a data byte. Read data appears one cycle after the read strobe and stays put until the next read. Everything else in the serial port lies outside this block: baud generation, the shift registers, the FIFOs and the remaining modem lines.

Top module: `modem_ctl_top`

## Requirements
- R1: With control register (offset 4) bit 4 clear, `rts_n` equals the inverse of control bit 1 and `dtr_n` equals the inverse of control bit 0, one cycle after the write.
- R2: While reset is held, `rts_n` and `dtr_n` are high, `irq` is low, and the control register (offset 4) and interrupt enable register (offset 1) reset to zero.
- R3: While control bit 4 (loopback) is set, `rts_n` and `dtr_n` are both high whatever bits 1 and 0 hold.
- R4: Status register (offset 6) bit 4 reads as the complement of `cts_n`, once `cts_n` has passed the two-flop synchronizer. A read strobe issued three or more cycles after a change returns the new value.
- R5: Status bit 0 (delta) is set by either edge of the synchronized clear-to-send signal and holds at 1 until a status read.
- R6: A status read returns the delta flag and then clears it. A change that is detected in the same cycle as the read leaves the flag set.
- R7: `irq` is high exactly while the delta flag and interrupt enable bit 3 are both 1. It drops after a status read clears the flag.
- R8: At the first clock edge after reset is released, `strap_in` is latched. A 0 gives `cfg_base` = 12'h3F0 and a 1 gives 12'h370. Later changes of `strap_in` have no effect until the next reset.
- R9: Changes of `cts_n` have no effect on `rts_n` or `dtr_n`.
- R10: Read data appears on `rdata` the cycle after `rd_en`. Interrupt enable and control registers read back their written low 4 and 5 bits. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| cts_n | input | 1 | Active-low clear-to-send, asynchronous |
| strap_in | input | 1 | Level of the shared request-to-send pin, sampled as a strap |
| rts_n | output | 1 | Active-low request-to-send |
| dtr_n | output | 1 | Active-low data-terminal-ready |
| irq | output | 1 | Modem-status interrupt |
| cfg_base | output | 12 | Selected configuration index base address |

## Verification
A stuck or lost delta flag shows within two reads. The read that should return it gives the wrong bit 0, and `irq` stays high or never rises in the same cycle the flag would. A wrong synchronizer depth shifts the moment status bit 4 flips by a cycle, so the bench samples that value exactly three cycles after the change and again two cycles after the change. A mislatched strap shows on `cfg_base` from the second cycle after reset release, and it must then survive a later change of `strap_in`.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int MH_ADDR_W = 3;
  localparam int MH_DATA_W = 8;

  localparam logic [MH_ADDR_W-1:0] OFS_IER = 3'd1;
  localparam logic [MH_ADDR_W-1:0] OFS_MCR = 3'd4;
  localparam logic [MH_ADDR_W-1:0] OFS_MSR = 3'd6;

  localparam int IER_W = 4;
  localparam int MCR_W = 5;

  localparam int MCR_DTR_BIT  = 0;
  localparam int MCR_RTS_BIT  = 1;
  localparam int MCR_LOOP_BIT = 4;
  localparam int IER_MS_BIT   = 3;
  localparam int MSR_DCTS_BIT = 0;
  localparam int MSR_CTS_BIT  = 4;

  typedef struct packed {
    logic [IER_W-1:0] ier;
    logic [MCR_W-1:0] mcr;
  } ctl_regs_t;
endpackage

// File: rtl/mh_sync.sv
module mh_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain[gi] <= RST_VAL;
        end else if (gi == 0) begin
          chain[gi] <= d;
        end else begin
          chain[gi] <= chain[(gi == 0) ? 0 : gi-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mh_ctrl_regs.sv
module mh_ctrl_regs
  import modem_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [MH_ADDR_W-1:0] addr,
  input  logic [MH_DATA_W-1:0] wdata,
  output ctl_regs_t            regs,
  output logic                 ms_irq_en,
  output logic                 rts_n,
  output logic                 dtr_n
);
  logic loop_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (wr_en) begin
      if (addr == OFS_IER) regs.ier <= wdata[IER_W-1:0];
      if (addr == OFS_MCR) regs.mcr <= wdata[MCR_W-1:0];
    end
  end

  assign loop_on   = regs.mcr[MCR_LOOP_BIT];
  assign ms_irq_en = regs.ier[IER_MS_BIT];

  // outputs are pulled to the inactive high level whenever loopback is on
  assign rts_n = ~(regs.mcr[MCR_RTS_BIT] & ~loop_on);
  assign dtr_n = ~(regs.mcr[MCR_DTR_BIT] & ~loop_on);
endmodule

// File: rtl/mh_status.sv
module mh_status
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cts_n,
  input  logic                 msr_rd,
  input  logic                 ms_irq_en,
  output logic [MH_DATA_W-1:0] msr,
  output logic                 delta,
  output logic                 cts_chg,
  output logic                 irq
);
  logic cts_n_s;
  logic cts_n_prev;

  mh_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cts_n),
    .q     (cts_n_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_n_prev <= 1'b1;
    else        cts_n_prev <= cts_n_s;
  end

  assign cts_chg = cts_n_s ^ cts_n_prev;

  // a change in the read cycle wins over the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) delta <= 1'b0;
    else        delta <= cts_chg | (delta & ~msr_rd);
  end

  always_comb begin
    msr               = '0;
    msr[MSR_CTS_BIT]  = ~cts_n_s;
    msr[MSR_DCTS_BIT] = delta;
  end

  assign irq = delta & ms_irq_en;
endmodule

// File: rtl/mh_strap.sv
module mh_strap #(
  parameter int            BASE_W  = 12,
  parameter logic [11:0]   BASE_LO = 12'h3F0,
  parameter logic [11:0]   BASE_HI = 12'h370
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_in,
  output logic [BASE_W-1:0] cfg_base,
  output logic              done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_base <= BASE_W'(BASE_LO);
      done     <= 1'b0;
    end else if (!done) begin
      cfg_base <= strap_in ? BASE_W'(BASE_HI) : BASE_W'(BASE_LO);
      done     <= 1'b1;
    end
  end
endmodule

// File: rtl/modem_ctl_top.sv
module modem_ctl_top
  import modem_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          BASE_W      = 12,
  parameter logic [11:0] BASE_LO     = 12'h3F0,
  parameter logic [11:0] BASE_HI     = 12'h370
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [MH_ADDR_W-1:0] addr,
  input  logic [MH_DATA_W-1:0] wdata,
  output logic [MH_DATA_W-1:0] rdata,
  input  logic                 cts_n,
  input  logic                 strap_in,
  output logic                 rts_n,
  output logic                 dtr_n,
  output logic                 irq,
  output logic [BASE_W-1:0]    cfg_base
);
  ctl_regs_t            regs_w;
  logic                 ms_en_w;
  logic                 msr_rd_w;
  logic [MH_DATA_W-1:0] msr_w;
  logic                 delta_w;
  logic                 cts_chg_w;
  logic                 strap_done_w;
  logic [MH_DATA_W-1:0] rd_mux;

  assign msr_rd_w = rd_en && (addr == OFS_MSR);

  mh_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .regs      (regs_w),
    .ms_irq_en (ms_en_w),
    .rts_n     (rts_n),
    .dtr_n     (dtr_n)
  );

  mh_status #(.SYNC_STAGES(SYNC_STAGES)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .cts_n     (cts_n),
    .msr_rd    (msr_rd_w),
    .ms_irq_en (ms_en_w),
    .msr       (msr_w),
    .delta     (delta_w),
    .cts_chg   (cts_chg_w),
    .irq       (irq)
  );

  mh_strap #(.BASE_W(BASE_W), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)) u_strap (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap_in (strap_in),
    .cfg_base (cfg_base),
    .done     (strap_done_w)
  );

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_IER: rd_mux[IER_W-1:0] = regs_w.ier;
      OFS_MCR: rd_mux[MCR_W-1:0] = regs_w.mcr;
      OFS_MSR: rd_mux            = msr_w;
      default: rd_mux            = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/modem_ctl_chk.sv
module modem_ctl_chk
  import modem_pkg::*;
#(
  parameter int BASE_W = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [MH_ADDR_W-1:0] addr,
  input logic [MH_DATA_W-1:0] wdata,
  input logic [MH_DATA_W-1:0] rdata,
  input logic                 rts_n,
  input logic                 dtr_n,
  input logic                 irq,
  input logic [BASE_W-1:0]    cfg_base,
  input logic                 delta,
  input logic                 cts_chg,
  input logic                 strap_done
);
  // R1
  rts_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MCR && !wdata[MCR_LOOP_BIT]) |=>
      (rts_n == !$past(wdata[MCR_RTS_BIT]) && dtr_n == !$past(wdata[MCR_DTR_BIT])));

  // R3
  loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MCR && wdata[MCR_LOOP_BIT]) |=> (rts_n && dtr_n));

  // R5
  delta_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (delta && !(rd_en && addr == OFS_MSR)) |=> delta);

  // R7
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFS_MSR && !cts_chg) |=> !irq);

  // R8
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> $stable(cfg_base));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind modem_ctl_top modem_ctl_chk #(.BASE_W(BASE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .rts_n      (rts_n),
  .dtr_n      (dtr_n),
  .irq        (irq),
  .cfg_base   (cfg_base),
  .delta      (delta_w),
  .cts_chg    (cts_chg_w),
  .strap_done (strap_done_w)
);

// File: tb/modem_ctl_top_tb.sv
module modem_ctl_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       cts_n = 1'b1;
  logic       strap_in = 1'b0;
  logic       rts_n, dtr_n, irq;
  logic [11:0] cfg_base;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_item_t;
  exp_item_t sb_q[$];
  logic rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  modem_ctl_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cts_n(cts_n), .strap_in(strap_in),
    .rts_n(rts_n), .dtr_n(dtr_n), .irq(irq), .cfg_base(cfg_base)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compare read data the cycle after each strobe
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen && sb_q.size() > 0) begin
      exp_item_t it;
      it = sb_q.pop_front();
      check(it.tag, {24'd0, rdata}, {24'd0, it.exp});
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    sb_q.push_back('{exp: exp, tag: tag});
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0; strap_in = strap;
    idle(3);
    check("R2 rts_n in reset", rts_n, 1);
    check("R2 dtr_n in reset", dtr_n, 1);
    check("R2 irq in reset", irq, 0);
    rst_n = 1'b1;
    idle(2);
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(1'b0);
    check("R8 strap 0 base", cfg_base, 12'h3F0);
    strap_in = 1'b1; idle(2);
    check("R8 strap ignored later", cfg_base, 12'h3F0);
    rd(3'd4, 8'h00, "R2 mcr reset");
    rd(3'd1, 8'h00, "R2 ier reset");

    // R1 output drive
    wr(3'd4, 8'h02);
    check("R1 rts active", rts_n, 0); check("R1 dtr idle", dtr_n, 1);
    wr(3'd4, 8'h01);
    check("R1 rts idle", rts_n, 1); check("R1 dtr active", dtr_n, 0);
    wr(3'd4, 8'h03);
    check("R1 both active rts", rts_n, 0); check("R1 both active dtr", dtr_n, 0);
    // R3 loop forces inactive
    wr(3'd4, 8'h13);
    check("R3 loop rts", rts_n, 1); check("R3 loop dtr", dtr_n, 1);
    rd(3'd4, 8'h13, "R10 mcr readback");
    wr(3'd4, 8'hE3);
    rd(3'd4, 8'h03, "R10 mcr width");
    rd(3'd7, 8'h00, "R10 unmapped");
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'h0F, "R10 ier readback");
    wr(3'd1, 8'h00);

    // R4/R5/R9 cts falls (asserted)
    cts_n = 1'b0;
    idle(1);
    check("R9 rts unaffected", rts_n, 0); check("R9 dtr unaffected", dtr_n, 0);
    idle(2);
    rd(3'd6, 8'h11, "R4 R5 cts asserted delta");
    rd(3'd6, 8'h10, "R6 delta cleared");
    check("R7 no irq when disabled", irq, 0);
    // R5 rising edge of cts_n also flags
    cts_n = 1'b1; idle(5);
    check("R7 irq masked", irq, 0);
    wr(3'd1, 8'h08);
    check("R7 irq on enable", irq, 1);
    rd(3'd6, 8'h01, "R5 cts released delta");
    check("R7 irq cleared by read", irq, 0);

    // R6 change in the read cycle is kept
    cts_n = 1'b0; idle(2);
    rd(3'd6, 8'h10, "R6 same-cycle read");
    check("R7 irq after collision", irq, 1);
    rd(3'd6, 8'h11, "R6 delta kept");
    check("R7 irq dropped", irq, 0);

    // R4 sync latency: two cycles is too early for the read
    cts_n = 1'b1; idle(1);
    rd(3'd6, 8'h10, "R4 sync latency");
    idle(3);
    rd(3'd6, 8'h01, "R4 settled");
    check("R9 outputs stay", {rts_n, dtr_n}, 2'b00);

    // R8 second reset with strap high
    do_reset(1'b1);
    check("R8 strap 1 base", cfg_base, 12'h370);
    strap_in = 1'b0; idle(2);
    check("R8 strap held", cfg_base, 12'h370);
    check("R2 rts after reset", rts_n, 1);
    rd(3'd1, 8'h00, "R2 ier cleared");
    idle(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule